// File: doc/BRIEF.md
# Clock Ratio Transition Sequencer

This block moves a processor core clock from one divide ratio to another and keeps the refresh settings of an attached DRAM controller safe during the move. A request names a target ratio index and is accepted on a one-cycle start strobe. The block then carries out a fixed series of register updates on its two outputs: the 3-bit divider mode word read by the clock generator, and a memory-control word read by the DRAM controller. The memory-control word holds a 7-bit refresh count and a self-refresh enable bit. Between the updates the block waits for the PLL to relock, and, when needed, for the old and new refresh periods to drain.

The refresh count for each ratio is computed at elaboration time from the base clock frequency parameter. The divide-by-1 setting and the ratios above 2 are never adjacent: such a move always passes through divide-by-2. Self-refresh is switched only on the edge between divide-by-1 and divide-by-2. Whether the refresh count is rewritten before or after the mode word depends on the direction of the move. `busy_o` covers the whole transition and `done_o` marks its end.

Top module: `clk_ratio_sequencer`

## Requirements
- R1: After reset the mode word is 000 (divide-by-1), self-refresh is clear, the refresh count holds the divide-by-1 value, and busy_o and done_o are low.
- R2: Target index 0, 1, 2, 3, 4 selects ratio 1, 2, 4, 6, 8; the mode word encodes these as 000, 001, 011, 010, 100 and never shows any other code.
- R3: mem_ctl_o carries the refresh count in bits 14:8 and the self-refresh enable in bit 16, with every other bit zero; the count for ratio d is floor(BASE_CLK_HZ * 7800 / (64 * d * 10^9)), capped at 127.
- R4: A move from divide-by-2 to divide-by-1 clears self-refresh, then writes the mode word, then rewrites the refresh count.
- R5: A move from divide-by-1 to divide-by-2 rewrites the refresh count, then writes the mode word, then sets self-refresh; self-refresh changes only while the mode word is 001.
- R6: A move between divide-by-1 and any ratio above 2 (either direction) is done as two legs through divide-by-2; the mode word never goes straight from 000 to a code other than 001, nor into 000 from a code other than 001.
- R7: Between two ratios of 2 or more, a slowing move rewrites the refresh count before the mode word, and a speeding move writes the mode word before the refresh count.
- R8: After each mode-word change, neither output register changes again for at least LOCK_CYCLES cycles.
- R9: In a slowing leg with self-refresh clear, at least 64 * (old count + new count) * old ratio cycles pass between the refresh-count write and the mode-word write.
- R10: A start whose target equals the current ratio gives a done_o pulse in the next cycle, never raises busy_o, and changes neither register.
- R11: A start strobe that arrives while busy_o is high is ignored: the running transition ends at its own target and no second transition follows.
- R12: A start whose target index is above 4 is ignored: no busy_o, no done_o, no register change.
- R13: busy_o rises in the cycle after an accepted start and stays high until done_o, which is a single-cycle pulse with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| target_i | input | 3 | Target ratio index, 0 to 4 |
| busy_o | output | 1 | Transition in progress |
| done_o | output | 1 | One-cycle pulse at the end of a request |
| div_mode_o | output | 3 | Divider mode word to the clock generator |
| mem_ctl_o | output | 17 | Memory-control word: count in 14:8, self-refresh in 16 |

## Verification
The bench builds the block with BASE_CLK_HZ at 100 MHz, LOCK_CYCLES at 16 and DRAIN_MARGIN at 4. At that base clock the five refresh counts are 12, 6, 3, 2 and 1: all differ, so every count rewrite shows up as a visible change on mem_ctl_o and its place in the order can be checked. The same setting keeps the divide-by-1 to divide-by-2 drain near 1150 cycles, so the two-leg moves, the self-refresh edges, the drain and the lock waits can all be walked through one after another, with an ignored strobe placed in the middle of a two-leg move.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;
  localparam int NUM_RATIOS = 5;
  localparam int IDX_W      = 3;
  localparam int MODE_W     = 3;
  localparam int RCNT_W     = 7;
  localparam int MCTL_W     = 17;
  localparam int RCNT_LSB   = 8;
  localparam int SREF_BIT   = 16;
  localparam int RCNT_MAX   = (1 << RCNT_W) - 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PLAN, ST_SR_CLR, ST_REFR, ST_DRAIN,
    ST_WMODE, ST_LOCK, ST_SR_SET, ST_LEG_END
  } seq_state_e;

  function automatic logic [3:0] ratio_of(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 4'd1;
      3'd1:    return 4'd2;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mode_of(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return 3'b000;
      3'd1:    return 3'b001;
      3'd2:    return 3'b011;
      3'd3:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [NUM_RATIOS*RCNT_W-1:0] refresh_table(input longint base_hz);
    logic [NUM_RATIOS*RCNT_W-1:0] t;
    longint c;
    t = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      c = (base_hz * 64'sd7800) /
          (64'sd64 * longint'(ratio_of(IDX_W'(i))) * 64'sd1000000000);
      if (c > longint'(RCNT_MAX)) c = longint'(RCNT_MAX);
      t[i*RCNT_W +: RCNT_W] = RCNT_W'(c);
    end
    return t;
  endfunction
endpackage

// File: rtl/seq_step_planner.sv
`timescale 1ns/1ps
module seq_step_planner
  import clkseq_pkg::*;
(
  input  logic [IDX_W-1:0] cur_idx_i,
  input  logic [IDX_W-1:0] final_idx_i,
  output logic [IDX_W-1:0] leg_idx_o,
  output logic             slow_o,
  output logic             sr_clr_o,
  output logic             sr_set_o
);
  logic through_div2;

  always_comb begin
    through_div2 = (cur_idx_i == 3'd0 && final_idx_i > 3'd1) ||
                   (cur_idx_i > 3'd1 && final_idx_i == 3'd0);
    leg_idx_o    = through_div2 ? 3'd1 : final_idx_i;
    slow_o       = leg_idx_o > cur_idx_i;
    sr_clr_o     = (cur_idx_i == 3'd1) && (leg_idx_o == 3'd0);
    sr_set_o     = (cur_idx_i == 3'd0) && (leg_idx_o == 3'd1);
  end
endmodule

// File: rtl/seq_wait_timer.sv
`timescale 1ns/1ps
module seq_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/clk_ratio_sequencer.sv
`timescale 1ns/1ps
module clk_ratio_sequencer
  import clkseq_pkg::*;
#(
  parameter longint BASE_CLK_HZ  = 500_000_000,
  parameter int     LOCK_CYCLES  = 16,
  parameter int     DRAIN_MARGIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  target_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [MODE_W-1:0] div_mode_o,
  output logic [MCTL_W-1:0] mem_ctl_o
);
  localparam logic [NUM_RATIOS*RCNT_W-1:0] RCNT_TBL = refresh_table(BASE_CLK_HZ);
  localparam int DRAIN_MAX = 64 * 2 * RCNT_MAX * 8 + DRAIN_MARGIN;
  localparam int TMR_W     = $clog2(DRAIN_MAX + LOCK_CYCLES + 1);

  seq_state_e        state_q;
  logic [IDX_W-1:0]  cur_idx_q, final_idx_q, leg_idx_q;
  logic              slow_q, sr_set_q, sref_q, busy_q, done_q;
  logic [RCNT_W-1:0] refr_q;
  logic [MODE_W-1:0] mode_q;

  logic [IDX_W-1:0]  plan_leg;
  logic              plan_slow, plan_sr_clr, plan_sr_set;
  logic [RCNT_W-1:0] leg_cnt;
  logic [TMR_W-1:0]  drain_len, tmr_val;
  logic              tmr_load, tmr_expired;

  seq_step_planner u_plan (
    .cur_idx_i   (cur_idx_q),
    .final_idx_i (final_idx_q),
    .leg_idx_o   (plan_leg),
    .slow_o      (plan_slow),
    .sr_clr_o    (plan_sr_clr),
    .sr_set_o    (plan_sr_set)
  );

  seq_wait_timer #(.W(TMR_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  // Count for the leg being executed, drain length uses the ratio still in force.
  assign leg_cnt   = RCNT_TBL[int'(leg_idx_q)*RCNT_W +: RCNT_W];
  assign drain_len = TMR_W'(64 * (int'(refr_q) + int'(leg_cnt)) *
                     int'(ratio_of(cur_idx_q)) + DRAIN_MARGIN);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = drain_len;
    if (state_q == ST_REFR && slow_q && !sref_q) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_WMODE) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(LOCK_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cur_idx_q   <= '0;
      final_idx_q <= '0;
      leg_idx_q   <= '0;
      slow_q      <= 1'b0;
      sr_set_q    <= 1'b0;
      sref_q      <= 1'b0;
      refr_q      <= RCNT_TBL[RCNT_W-1:0];
      mode_q      <= mode_of(3'd0);
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i && (int'(target_i) < NUM_RATIOS)) begin
            if (target_i == cur_idx_q) begin
              done_q <= 1'b1;
            end else begin
              final_idx_q <= target_i;
              busy_q      <= 1'b1;
              state_q     <= ST_PLAN;
            end
          end
        end
        ST_PLAN: begin
          leg_idx_q <= plan_leg;
          slow_q    <= plan_slow;
          sr_set_q  <= plan_sr_set;
          if (plan_sr_clr)    state_q <= ST_SR_CLR;
          else if (plan_slow) state_q <= ST_REFR;
          else                state_q <= ST_WMODE;
        end
        ST_SR_CLR: begin
          sref_q  <= 1'b0;
          state_q <= ST_WMODE;
        end
        ST_REFR: begin
          refr_q <= leg_cnt;
          if (!slow_q)     state_q <= ST_LEG_END;
          else if (!sref_q) state_q <= ST_DRAIN;
          else             state_q <= ST_WMODE;
        end
        ST_DRAIN: begin
          if (tmr_expired) state_q <= ST_WMODE;
        end
        ST_WMODE: begin
          mode_q    <= mode_of(leg_idx_q);
          cur_idx_q <= leg_idx_q;
          state_q   <= ST_LOCK;
        end
        ST_LOCK: begin
          if (tmr_expired) begin
            if (!slow_q)       state_q <= ST_REFR;
            else if (sr_set_q) state_q <= ST_SR_SET;
            else               state_q <= ST_LEG_END;
          end
        end
        ST_SR_SET: begin
          sref_q  <= 1'b1;
          state_q <= ST_LEG_END;
        end
        ST_LEG_END: begin
          if (cur_idx_q == final_idx_q) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PLAN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign div_mode_o = mode_q;
  assign mem_ctl_o  = {sref_q, 1'b0, refr_q, {RCNT_LSB{1'b0}}};
endmodule

// File: rtl/clk_ratio_sequencer_chk.sv
`timescale 1ns/1ps
module clk_ratio_sequencer_chk
  import clkseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic [MODE_W-1:0] div_mode_o,
  input logic [MCTL_W-1:0] mem_ctl_o
);
  logic [MODE_W-1:0] prev_mode;
  logic [MCTL_W-1:0] prev_mctl;
  int                gap_q;

  always_ff @(posedge clk) begin
    prev_mode <= div_mode_o;
    prev_mctl <= mem_ctl_o;
    if (rst)                          gap_q <= LOCK_CYCLES;
    else if (div_mode_o != prev_mode) gap_q <= 1;
    else if (gap_q < LOCK_CYCLES)     gap_q <= gap_q + 1;
  end

  p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
    div_mode_o inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});

  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (div_mode_o != prev_mode || mem_ctl_o != prev_mctl) |-> gap_q >= LOCK_CYCLES);

  p_sref_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_ctl_o[SREF_BIT] != prev_mctl[SREF_BIT]) |-> div_mode_o == 3'b001);

  p_via_div2_r6: assert property (@(posedge clk) disable iff (rst)
    (div_mode_o != prev_mode && (prev_mode == 3'b000 || div_mode_o == 3'b000))
      |-> (prev_mode == 3'b001 || div_mode_o == 3'b001));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

bind clk_ratio_sequencer clk_ratio_sequencer_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .div_mode_o (div_mode_o),
  .mem_ctl_o  (mem_ctl_o)
);

// File: tb/sim_clk_ratio_sequencer.sv
`timescale 1ns/1ps
module sim_clk_ratio_sequencer;
  localparam longint BASE = 100_000_000;
  localparam int     LOCK = 16;
  localparam int     MARG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  target_i = 3'd0;
  logic        busy_o, done_o;
  logic [2:0]  div_mode_o;
  logic [16:0] mem_ctl_o;

  always #10 clk = ~clk;

  clk_ratio_sequencer #(.BASE_CLK_HZ(BASE), .LOCK_CYCLES(LOCK), .DRAIN_MARGIN(MARG)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .target_i(target_i),
    .busy_o(busy_o), .done_o(done_o), .div_mode_o(div_mode_o), .mem_ctl_o(mem_ctl_o)
  );

  typedef struct {
    bit          is_mode;
    logic [16:0] val;
    int          min_gap;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   m_idx = 0;
  bit   m_sref = 0;
  bit   last_mode = 0;
  bit   finished = 0;

  function automatic int ratio(int i);
    case (i) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
  endfunction
  function automatic logic [2:0] code(int i);
    case (i) 0: return 3'b000; 1: return 3'b001; 2: return 3'b011; 3: return 3'b010; default: return 3'b100; endcase
  endfunction
  function automatic int cnt(int i);
    longint c = (BASE * 7800) / (64 * longint'(ratio(i)) * 1000000000);
    return (c > 127) ? 127 : int'(c);
  endfunction
  function automatic logic [16:0] mctl(bit s, int c);
    return {s, 1'b0, 7'(c), 8'h00};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(bit is_mode, logic [16:0] v, int g, string tag);
    exp_t e;
    e.is_mode = is_mode; e.val = v; e.min_gap = g; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic plan_leg(int o, int n, string tag);
    int g;
    g = last_mode ? LOCK : 1;
    if (o == 1 && n == 0) begin
      m_sref = 0;
      push(0, mctl(0, cnt(o)), g, {tag, " R3"});
      push(1, 17'(code(n)), 1, {tag, " R2"});
      push(0, mctl(0, cnt(n)), LOCK, {tag, " R8"});
      last_mode = 0;
    end else if (n > o) begin
      push(0, mctl(m_sref, cnt(n)), g, {tag, " R3"});
      push(1, 17'(code(n)), m_sref ? 1 : 64 * (cnt(o) + cnt(n)) * ratio(o),
           m_sref ? {tag, " R2"} : {tag, " R9"});
      if (o == 0 && n == 1) begin
        m_sref = 1;
        push(0, mctl(1, cnt(n)), LOCK, {tag, " R8"});
        last_mode = 0;
      end else begin
        last_mode = 1;
      end
    end else begin
      push(1, 17'(code(n)), g, {tag, " R2"});
      push(0, mctl(m_sref, cnt(n)), LOCK, {tag, " R8"});
      last_mode = 0;
    end
  endtask

  task automatic expect_move(int tgt, string tag);
    last_mode = 0;
    while (m_idx != tgt) begin
      int leg;
      leg = ((m_idx == 0 && tgt > 1) || (m_idx > 1 && tgt == 0)) ? 1 : tgt;
      plan_leg(m_idx, leg, tag);
      m_idx = leg;
    end
  endtask

  task automatic pulse(int tgt);
    target_i = 3'(tgt);
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
  endtask

  task automatic wait_done(string tag);
    int n = 0;
    while (!done_o && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(done_o === 1'b1, {tag, " R13 done"}, 32'(done_o), 1);
    check(busy_o === 1'b0, {tag, " R13 idle at done"}, 32'(busy_o), 0);
    check(q.size() == 0, {tag, " missing events"}, q.size(), 0);
    check(div_mode_o == code(m_idx), {tag, " final mode"}, 32'(div_mode_o), 32'(code(m_idx)));
    check(mem_ctl_o == mctl(m_sref, cnt(m_idx)), {tag, " final mctl R3"},
          32'(mem_ctl_o), 32'(mctl(m_sref, cnt(m_idx))));
  endtask

  task automatic request(int tgt, string tag);
    expect_move(tgt, tag);
    pulse(tgt);
    check(busy_o === 1'b1, {tag, " R13 busy after start"}, 32'(busy_o), 1);
    wait_done(tag);
    @(negedge clk);
  endtask

  // Monitor: every register change must match the head of the expected queue.
  initial begin
    logic [2:0]  pm;
    logic [16:0] pc;
    int          gap;
    exp_t        e;
    gap = 0;
    @(negedge clk);
    while (rst) @(negedge clk);
    pm = div_mode_o; pc = mem_ctl_o;
    forever begin
      @(negedge clk);
      gap++;
      if (div_mode_o != pm || mem_ctl_o != pc) begin
        if (q.size() == 0) begin
          check(0, "unexpected register change R10/R11/R12", {12'd0, div_mode_o, mem_ctl_o}, {12'd0, pm, pc});
        end else begin
          e = q.pop_front();
          if (e.is_mode) begin
            check(div_mode_o != pm && mem_ctl_o == pc, {e.tag, " expected mode write"}, 32'(div_mode_o), 32'(e.val));
            check(div_mode_o == e.val[2:0], {e.tag, " mode value"}, 32'(div_mode_o), 32'(e.val));
          end else begin
            check(mem_ctl_o != pc && div_mode_o == pm, {e.tag, " expected mctl write"}, 32'(mem_ctl_o), 32'(e.val));
            check(mem_ctl_o == e.val, {e.tag, " mctl value"}, 32'(mem_ctl_o), 32'(e.val));
          end
          check(gap >= e.min_gap, {e.tag, " spacing"}, gap, e.min_gap);
        end
        gap = 0;
        pm = div_mode_o; pc = mem_ctl_o;
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(div_mode_o == 3'b000, "R1 mode", 32'(div_mode_o), 0);
    check(mem_ctl_o == mctl(0, cnt(0)), "R1 mctl", 32'(mem_ctl_o), 32'(mctl(0, cnt(0))));
    check(busy_o == 0 && done_o == 0, "R1 busy/done", {30'd0, busy_o, done_o}, 0);

    request(1, "R5 1->2");
    request(0, "R4 2->1");
    request(4, "R6 1->8");
    request(2, "R7 speed 8->4");
    request(3, "R7 slow 4->6");
    request(0, "R6 6->1");

    // R10: target equals current ratio
    pulse(0);
    check(done_o === 1'b1, "R10 done pulse", 32'(done_o), 1);
    check(busy_o === 1'b0, "R10 no busy", 32'(busy_o), 0);
    @(negedge clk);
    check(done_o === 1'b0, "R10 single pulse", 32'(done_o), 0);
    check(q.size() == 0, "R10 no events", q.size(), 0);

    // R12: out-of-range target
    pulse(5);
    check(busy_o == 0 && done_o == 0, "R12 ignored", {30'd0, busy_o, done_o}, 0);
    repeat (30) @(negedge clk);
    check(div_mode_o == 3'b000, "R12 mode kept", 32'(div_mode_o), 0);

    // R11: strobe while busy is ignored
    expect_move(3, "R11 1->6");
    pulse(3);
    repeat (5) @(negedge clk);
    pulse(0);
    wait_done("R11 1->6");
    repeat (40) @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R11 no second run", {30'd0, busy_o, done_o}, 0);
    check(div_mode_o == code(3), "R11 stays at /6", 32'(div_mode_o), 32'(code(3)));

    request(4, "R7 slow 6->8");
    request(1, "R7 speed 8->2");

    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule